// File: doc/BRIEF.md
# Four-Bit Shift/Load Register with JK First Stage

This block is a small register of `WIDTH` stages (four by default). It has two modes. It shifts toward the higher-numbered stage, or it loads all stages in parallel. The active-low mode input `load_n` picks the mode, and every transfer happens on the rising edge of `clk`.

During a shift, stage 0 does not take a plain serial bit. It takes a JK-style pair whose K input is inverted, `j_in` and `kn_in`. With this pair the first stage can clear, set, hold or toggle its own value while the other stages move along by one. Tying `j_in` and `kn_in` together gives an ordinary serial data input.

A clear input `rst` is active high and asynchronous. The outputs are the true stage values and a registered complement of the last stage. To cascade two registers, feed the last stage of one into the tied J/K inputs of the next.

Top module: `jkreg_shift4`

## Requirements
- R1: Raising `rst` clears every bit of `q` to 0 and sets `q_last_n` to 1 at once, with no clock edge needed.
- R2: While `rst` is high, rising clock edges leave `q` at 0 whatever the values of `load_n`, `par_d`, `j_in` and `kn_in`.
- R3: When `load_n` is 0 at a rising edge, `q` takes `par_d` bit for bit, and `j_in` / `kn_in` have no effect.
- R4: When `load_n` is 1 at a rising edge, each `q[i]` for i ≥ 1 takes the old `q[i-1]`. The old last-stage value is dropped and `par_d` has no effect.
- R5: In shift mode with `j_in`=0 and `kn_in`=0, the new `q[0]` is 0.
- R6: In shift mode with `j_in`=1 and `kn_in`=1, the new `q[0]` is 1. Together with R5, tying both inputs to one signal makes a plain D input.
- R7: In shift mode with `j_in`=0 and `kn_in`=1, `q[0]` keeps its old value.
- R8: In shift mode with `j_in`=1 and `kn_in`=0, `q[0]` takes the inverse of its old value.
- R9: Outside reset, `q_last_n` always equals the inverse of `q[WIDTH-1]`.
- R10: The mode is sampled separately at every edge, so alternating load and shift on consecutive edges applies each edge's own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all stages |
| rst | input | 1 | Asynchronous clear, active high |
| load_n | input | 1 | 0 = parallel load, 1 = shift |
| j_in | input | 1 | First-stage J input (shift mode) |
| kn_in | input | 1 | First-stage inverted-K input (shift mode) |
| par_d | input | WIDTH | Parallel data, bit i loads stage i |
| q | output | WIDTH | Stage outputs, bit 0 is the first stage |
| q_last_n | output | 1 | Registered complement of the last stage |

## Verification
Every stage is a port, so a wrong stage value shows on `q` at the same edge where it goes wrong. The value also moves one bit higher on each following shift. A wrong first-stage decode therefore appears in `q[0]` right away. A bad complement register shows as `q_last_n` equal to `q[WIDTH-1]` in the same cycle. A reset that waited for a clock would leave `q` non-zero in the half cycle between a mid-cycle clear and the next edge.

// File: rtl/jkreg_pkg.sv
package jkreg_pkg;

  typedef enum logic [1:0] {
    JK_CLEAR  = 2'b00,
    JK_HOLD   = 2'b01,
    JK_TOGGLE = 2'b10,
    JK_SET    = 2'b11
  } jk_action_t;

  function automatic jk_action_t jk_decode(input logic j, input logic kn);
    jk_action_t a;
    case ({j, kn})
      2'b00:   a = JK_CLEAR;
      2'b01:   a = JK_HOLD;
      2'b10:   a = JK_TOGGLE;
      default: a = JK_SET;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/jkreg_first_stage.sv
module jkreg_first_stage
  import jkreg_pkg::*;
(
  input  logic j_in,
  input  logic kn_in,
  input  logic cur_q0,
  output logic ser_next
);
  jk_action_t act;

  always_comb begin
    act = jk_decode(j_in, kn_in);
    case (act)
      JK_CLEAR:  ser_next = 1'b0;
      JK_SET:    ser_next = 1'b1;
      JK_HOLD:   ser_next = cur_q0;
      JK_TOGGLE: ser_next = ~cur_q0;
      default:   ser_next = 1'b0;
    endcase
  end
endmodule

// File: rtl/jkreg_stage.sv
module jkreg_stage (
  input  logic clk,
  input  logic rst,
  input  logic load_n,
  input  logic par_bit,
  input  logic ser_bit,
  output logic d_next,
  output logic q_bit
);
  always_comb d_next = load_n ? ser_bit : par_bit;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) q_bit <= 1'b0;
    else     q_bit <= d_next;
  end
endmodule

// File: rtl/jkreg_last_out.sv
module jkreg_last_out (
  input  logic clk,
  input  logic rst,
  input  logic last_next,
  output logic q_last_n
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) q_last_n <= 1'b1;
    else     q_last_n <= ~last_next;
  end
endmodule

// File: rtl/jkreg_shift4.sv
module jkreg_shift4 #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic             j_in,
  input  logic             kn_in,
  input  logic [WIDTH-1:0] par_d,
  output logic [WIDTH-1:0] q,
  output logic             q_last_n
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] ser_in;
  logic [WIDTH-1:0] nxt;
  logic             first_ser;

  jkreg_first_stage u_first (
    .j_in    (j_in),
    .kn_in   (kn_in),
    .cur_q0  (q[0]),
    .ser_next(first_ser)
  );

  always_comb begin
    ser_in[0] = first_ser;
    for (int i = 1; i < WIDTH; i++) ser_in[i] = q[i-1];
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    jkreg_stage u_stage (
      .clk    (clk),
      .rst    (rst),
      .load_n (load_n),
      .par_bit(par_d[g]),
      .ser_bit(ser_in[g]),
      .d_next (nxt[g]),
      .q_bit  (q[g])
    );
  end

  jkreg_last_out u_last (
    .clk      (clk),
    .rst      (rst),
    .last_next(nxt[LAST]),
    .q_last_n (q_last_n)
  );
endmodule

// File: rtl/jkreg_shift4_chk.sv
module jkreg_shift4_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             load_n,
  input logic             j_in,
  input logic             kn_in,
  input logic [WIDTH-1:0] par_d,
  input logic [WIDTH-1:0] q,
  input logic             q_last_n
);
  a_r1_clear: assert property (@(posedge clk) rst |-> (q == '0 && q_last_n));
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> q == $past(par_d));
  a_r4_shift: assert property (@(posedge clk) disable iff (rst)
    load_n |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0]));
  a_r6_tied: assert property (@(posedge clk) disable iff (rst)
    (load_n && (j_in == kn_in)) |=> q[0] == $past(j_in));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (load_n && !j_in && kn_in) |=> q[0] == $past(q[0]));
  a_r8_toggle: assert property (@(posedge clk) disable iff (rst)
    (load_n && j_in && !kn_in) |=> q[0] != $past(q[0]));
  a_r9_compl: assert property (@(posedge clk) disable iff (rst)
    q_last_n == ~q[WIDTH-1]);
endmodule

bind jkreg_shift4 jkreg_shift4_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/jkreg_shift4_tb_top.sv
module jkreg_shift4_tb_top;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b0;
  logic         load_n = 1'b0;
  logic         j_in = 1'b0;
  logic         kn_in = 1'b0;
  logic [W-1:0] par_d = '0;
  logic [W-1:0] q;
  logic         q_last_n;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;
  bit  mdl[$];

  always #2.5 clk = ~clk;

  jkreg_shift4 #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .load_n(load_n), .j_in(j_in), .kn_in(kn_in),
    .par_d(par_d), .q(q), .q_last_n(q_last_n)
  );

  // behavioural model: mdl[0] is stage 0
  always @(posedge clk or posedge rst) begin
    if (rst) begin
      mdl = {};
      for (int i = 0; i < W; i++) mdl.push_back(1'b0);
    end else if (!load_n) begin
      mdl = {};
      for (int i = 0; i < W; i++) mdl.push_back(par_d[i]);
    end else begin
      bit nb;
      if (!j_in && !kn_in)     nb = 1'b0;
      else if (j_in && kn_in)  nb = 1'b1;
      else if (!j_in && kn_in) nb = mdl[0];
      else                     nb = ~mdl[0];
      void'(mdl.pop_back());
      mdl.push_front(nb);
    end
  end

  function automatic logic [W-1:0] mdl_vec();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = mdl[i];
    return v;
  endfunction

  task automatic check(string req);
    logic [W-1:0] e;
    e = mdl_vec();
    n_tests++;
    if (q !== e) begin
      n_fail++;
      $display("FAIL %s: q=%b expected %b", req, q, e);
    end
    n_tests++;
    if (q_last_n !== ~e[W-1]) begin
      n_fail++;
      $display("FAIL R9: q_last_n=%b expected %b", q_last_n, ~e[W-1]);
    end
  endtask

  // drive at negedge, one rising edge, compare at next negedge
  task automatic step(logic ld, logic j, logic kn, logic [W-1:0] d, string req);
    load_n = ld; j_in = j; kn_in = kn; par_d = d;
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1 rst = 1'b1;
    @(negedge clk);
    check("R1");
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R3: load, JK values must not matter
    step(1'b0, 1'b1, 1'b0, 4'b1010, "R3");
    step(1'b0, 1'b0, 1'b1, 4'b0110, "R3");
    step(1'b0, 1'b1, 1'b1, 4'b0001, "R3");
    // R4: shift with changing par_d (ignored), R5 clear into stage 0
    step(1'b1, 1'b0, 1'b0, 4'b1111, "R4");
    step(1'b1, 1'b0, 1'b0, 4'b1111, "R5");
    // R6 set
    step(1'b1, 1'b1, 1'b1, 4'b0000, "R6");
    step(1'b1, 1'b1, 1'b1, 4'b0101, "R6");
    // R7 hold
    step(1'b1, 1'b0, 1'b1, 4'b0000, "R7");
    step(1'b1, 1'b0, 1'b1, 4'b1000, "R7");
    // R8 toggle
    step(1'b1, 1'b1, 1'b0, 4'b0000, "R8");
    step(1'b1, 1'b1, 1'b0, 4'b0000, "R8");
    step(1'b1, 1'b1, 1'b0, 4'b1111, "R8");
    step(1'b1, 1'b0, 1'b1, 4'b0000, "R7");
    step(1'b1, 1'b0, 1'b0, 4'b0000, "R5");
    // R10: alternate mode every edge
    for (int k = 0; k < 16; k++) begin
      logic [W-1:0] d;
      d = W'(k * 5 + 3);
      step(k[0], k[1], k[2], d, "R10");
    end
    // tied D input pattern
    for (int k = 0; k < 12; k++) begin
      logic b;
      b = logic'((k * 7 + 1) % 3 == 0);
      step(1'b1, b, b, 4'b1001, "R6");
    end

    // R1: reset asserted mid-cycle, no edge needed
    step(1'b0, 1'b0, 1'b0, 4'b1111, "R3");
    #1 rst = 1'b1;
    #0.5 check("R1");
    // R2: hold reset across edges with load and shift requested
    load_n = 1'b0; par_d = 4'b1111;
    @(posedge clk);
    @(negedge clk);
    check("R2");
    load_n = 1'b1; j_in = 1'b1; kn_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2");
    rst = 1'b0;
    step(1'b1, 1'b1, 1'b1, 4'b0000, "R6");
    step(1'b0, 1'b0, 1'b0, 4'b1100, "R10");
    step(1'b1, 1'b1, 1'b0, 4'b0000, "R10");

    // pseudo-random mix
    for (int k = 0; k < 200; k++) begin
      logic [6:0] r;
      r = 7'($urandom);
      step(r[6] | r[5], r[4], r[3], r[3:0] ^ r[6:3], "R10");
    end
    finish_run();
  end

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end
endmodule